// File: doc/BRIEF.md
# Interrupt Expander with Presence Identification

This block collects up to sixteen interrupt lines from a plug-in board and turns them into one active-low level request toward a host processor. Each input is brought into the block clock domain through a two-stage synchronizer. A rising edge on the synchronized line sets a sticky pending bit. The host sees a request whenever a pending bit is set and its mask bit is clear. The host walks the pending bits that are not masked, lowest index first, and handles each one.

Software uses a simple synchronous 16-bit register bus. It can probe three fixed identification words and a revision word to decide whether the board is fitted. It enables and disables sources through a mask word. It retires pending bits through a separate clear word. The host writes ones to the clear word and then writes zero. While a clear bit is held at one, the matching pending bit is held at zero and new edges on that line are not recorded.

Top module: `irq_expander`

## Requirements
- R1: After reset the mask reads 0xFFFF (every source disabled), the status reads 0x0000 and `irq_n` is high.
- R2: Reads at byte offset 0x8 return 0xAAAA, at 0xA return 0x5555 and at 0xC return 0xCAFE. A read at 0x6 returns the `VERSION` parameter, which defaults to 0x0103. Read data appears on `bus_rdata` after the clock edge that samples the read.
- R3: Reads of the clear word (0x4), of odd offsets and of 0xE return 0. Writes to the status, version and identification offsets change nothing that can be read back.
- R4: A rising edge on `src_i[k]` sets status bit k (offset 0x0) no later than the third clock edge after the edge. The bit stays set while the source holds its level, and a source that stays high does not set the bit again after it is cleared.
- R5: The clear word (offset 0x4) holds the last value written to it. A status bit whose clear bit is 1 is zero from the next clock edge onward, and it stays zero even if a source edge arrives while the clear bit is held. Clear bits that are 0 leave status unchanged.
- R6: The mask word (offset 0x2) can be read and written. A mask bit of 1 disables source k. `irq_n` is driven low from a register, one clock edge after (status AND NOT mask) becomes nonzero.
- R7: A status bit can be set, and can be read, while its source is masked.
- R8: `irq_n` returns high on the clock edge after (status AND NOT mask) becomes zero. When the last pending bit is cleared, this is the second edge after the write to the clear word.
- R9: The start-up sequence is: mask 0, clear 0xFFFF, clear 0, mask 0x1F. After it the mask reads 0x001F and the status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| src_i | input | 16 | Asynchronous interrupt source lines |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_n | output | 1 | Active-low level interrupt toward the host |

## Verification
The two functions that can land on the same status bit in the same cycle are the recording of a source edge and a held clear. The bench writes a one into a clear bit first. It then raises that source so that the synchronized edge arrives while the clear is still held. It then expects the status bit to read zero, and to read zero again after the clear bit is released while the source stays high. The bit is then set only by a fresh edge. The release of `irq_n` is also judged cycle by cycle after the last pending bit is cleared: it stays low for one more edge and then goes high.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

  localparam logic [15:0] ID_WORD0 = 16'hAAAA;
  localparam logic [15:0] ID_WORD1 = 16'h5555;
  localparam logic [15:0] ID_WORD2 = 16'hCAFE;

  typedef enum logic [2:0] {
    RSEL_STATUS = 3'd0,
    RSEL_MASK   = 3'd1,
    RSEL_CLEAR  = 3'd2,
    RSEL_VER    = 3'd3,
    RSEL_ID0    = 3'd4,
    RSEL_ID1    = 3'd5,
    RSEL_ID2    = 3'd6,
    RSEL_NONE   = 3'd7
  } reg_sel_e;

  // Word index is the byte offset divided by two; odd offsets map nowhere.
  function automatic reg_sel_e decode_offset(input logic [3:0] off);
    reg_sel_e s;
    if (off[0]) begin
      s = RSEL_NONE;
    end else begin
      case (off[3:1])
        3'd0:    s = RSEL_STATUS;
        3'd1:    s = RSEL_MASK;
        3'd2:    s = RSEL_CLEAR;
        3'd3:    s = RSEL_VER;
        3'd4:    s = RSEL_ID0;
        3'd5:    s = RSEL_ID1;
        3'd6:    s = RSEL_ID2;
        default: s = RSEL_NONE;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/irqx_rst_sync.sv
module irqx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irqx_src_sync.sv
module irqx_src_sync #(
  parameter int N_SRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  output logic [N_SRC-1:0] rise_o
);
  for (genvar k = 0; k < N_SRC; k++) begin : g_line
    logic meta_q, sync_q, prev_q;
    logic meta_d, sync_d, prev_d;

    always_comb begin
      meta_d = src_i[k];
      sync_d = meta_q;
      prev_d = sync_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= meta_d;
        sync_q <= sync_d;
        prev_q <= prev_d;
      end
    end

    assign rise_o[k] = sync_q & ~prev_q;
  end
endmodule

// File: rtl/irqx_status.sv
module irqx_status #(
  parameter int N_SRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] rise_i,
  input  logic [N_SRC-1:0] clr_hold_i,
  output logic [N_SRC-1:0] status_o
);
  logic [N_SRC-1:0] status_q;
  logic [N_SRC-1:0] status_d;

  // A held clear bit dominates any edge arriving in the same cycle.
  always_comb begin
    status_d = (status_q | rise_i) & ~clr_hold_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status_o = status_q;
endmodule

// File: rtl/irqx_regs.sv
module irqx_regs
  import irqx_pkg::*;
#(
  parameter int          DATA_W  = 16,
  parameter int          ADDR_W  = 4,
  parameter int          N_SRC   = 16,
  parameter logic [15:0] VERSION = 16'h0103
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [N_SRC-1:0]  status_i,
  output logic [N_SRC-1:0]  mask_o,
  output logic [N_SRC-1:0]  clr_hold_o,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int PAD_W = DATA_W - N_SRC;

  reg_sel_e          sel;
  logic              wr_en, rd_en;
  logic              mask_en, clr_en;
  logic [N_SRC-1:0]  mask_q, mask_d;
  logic [N_SRC-1:0]  clr_q, clr_d;
  logic [DATA_W-1:0] rdata_q, rdata_d, rd_mux;

  always_comb begin
    sel     = decode_offset(bus_addr[3:0]);
    wr_en   = bus_sel & bus_wr;
    rd_en   = bus_sel & ~bus_wr;
    mask_en = wr_en & (sel == RSEL_MASK);
    clr_en  = wr_en & (sel == RSEL_CLEAR);
    mask_d  = bus_wdata[N_SRC-1:0];
    clr_d   = bus_wdata[N_SRC-1:0];
  end

  always_comb begin
    case (sel)
      RSEL_STATUS: rd_mux = {{PAD_W{1'b0}}, status_i};
      RSEL_MASK:   rd_mux = {{PAD_W{1'b0}}, mask_q};
      RSEL_VER:    rd_mux = VERSION;
      RSEL_ID0:    rd_mux = ID_WORD0;
      RSEL_ID1:    rd_mux = ID_WORD1;
      RSEL_ID2:    rd_mux = ID_WORD2;
      default:     rd_mux = '0;
    endcase
    rdata_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      clr_q <= '0;
    else if (clr_en) clr_q <= clr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign mask_o     = mask_q;
  assign clr_hold_o = clr_q;
  assign bus_rdata  = rdata_q;
endmodule

// File: rtl/irq_expander.sv
module irq_expander #(
  parameter int          DATA_W  = 16,
  parameter int          ADDR_W  = 4,
  parameter int          N_SRC   = 16,
  parameter logic [15:0] VERSION = 16'h0103
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_n
);
  logic             rst_sync_n;
  logic [N_SRC-1:0] rise;
  logic [N_SRC-1:0] status;
  logic [N_SRC-1:0] mask;
  logic [N_SRC-1:0] clr_hold;
  logic             pend_any;
  logic             irq_n_q, irq_n_d;

  irqx_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irqx_src_sync #(.N_SRC(N_SRC)) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .src_i  (src_i),
    .rise_o (rise)
  );

  irqx_status #(.N_SRC(N_SRC)) u_stat (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rise_i     (rise),
    .clr_hold_i (clr_hold),
    .status_o   (status)
  );

  irqx_regs #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .N_SRC   (N_SRC),
    .VERSION (VERSION)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .status_i   (status),
    .mask_o     (mask),
    .clr_hold_o (clr_hold),
    .bus_rdata  (bus_rdata)
  );

  always_comb begin
    pend_any = |(status & ~mask);
    irq_n_d  = ~pend_any;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_n_q <= 1'b1;
    else             irq_n_q <= irq_n_d;
  end

  assign irq_n = irq_n_q;
endmodule

// File: rtl/irqx_chk.sv
module irqx_chk #(
  parameter int          DATA_W  = 16,
  parameter int          ADDR_W  = 4,
  parameter int          N_SRC   = 16,
  parameter logic [15:0] VERSION = 16'h0103
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [N_SRC-1:0]  status,
  input logic [N_SRC-1:0]  mask,
  input logic [N_SRC-1:0]  clr_hold,
  input logic              irq_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata
);
  // R6 / R8: output level trails pending set by exactly one edge
  p_irq_level_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_n == ~(|($past(status) & ~$past(mask))));

  // R5: a held clear bit keeps status at zero
  p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (status & $past(clr_hold)) == '0);

  // R4: status bits only fall when a clear was held
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(status) & ~status & ~$past(clr_hold)) == '0);

  // R2: identification words
  p_id0_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_sel && !bus_wr && bus_addr == 4'h8) |=> bus_rdata == 16'hAAAA);
  p_id2_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_sel && !bus_wr && bus_addr == 4'hC) |=> bus_rdata == 16'hCAFE);
  p_ver_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_sel && !bus_wr && bus_addr == 4'h6) |=> bus_rdata == VERSION);

  // R3: the clear word reads as zero
  p_clr_reads0_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_sel && !bus_wr && bus_addr == 4'h4) |=> bus_rdata == '0);
endmodule

bind irq_expander irqx_chk #(
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .N_SRC   (N_SRC),
  .VERSION (VERSION)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .status     (status),
  .mask       (mask),
  .clr_hold   (clr_hold),
  .irq_n      (irq_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata)
);

// File: tb/irq_expander_tb.sv
module irq_expander_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] src_i;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq_n;

  always #2.5 clk = ~clk;

  irq_expander u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  typedef struct {
    bit          is_irq;
    logic [15:0] exp;
    int          due;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops expected items when their cycle has come and compares.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [15:0] act;
      it  = q.pop_front();
      act = it.is_irq ? {15'd0, irq_n} : bus_rdata;
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] e, input string tag);
    item_t it;
    it.is_irq = 1'b0; it.exp = e; it.due = cyc + 1; it.tag = tag;
    q.push_back(it);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = {15'd0, e}; it.due = cyc + 1; it.tag = tag;
    q.push_back(it);
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_i = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(4'h0, 16'h0000, "R1 status after reset");
    rd(4'h2, 16'hFFFF, "R1 mask after reset");
    chk_irq(1'b1, "R1 irq_n after reset"); idle(1);

    // R2 identification and version
    rd(4'h8, 16'hAAAA, "R2 id word 0");
    rd(4'hA, 16'h5555, "R2 id word 1");
    rd(4'hC, 16'hCAFE, "R2 id word 2");
    rd(4'h6, 16'h0103, "R2 version");

    // R3 zero reads and ignored writes
    rd(4'hE, 16'h0000, "R3 unmapped 0xE");
    rd(4'h3, 16'h0000, "R3 odd offset");
    wr(4'h4, 16'h0000);
    rd(4'h4, 16'h0000, "R3 clear word reads zero");
    wr(4'h8, 16'h1234);
    rd(4'h8, 16'hAAAA, "R3 id write ignored");
    wr(4'h0, 16'hFFFF);
    rd(4'h0, 16'h0000, "R3 status write ignored");
    wr(4'h6, 16'h0000);
    rd(4'h6, 16'h0103, "R3 version write ignored");

    // R9 start-up sequence
    wr(4'h2, 16'h0000);
    wr(4'h4, 16'hFFFF);
    wr(4'h4, 16'h0000);
    wr(4'h2, 16'h001F);
    rd(4'h2, 16'h001F, "R9 mask after init");
    rd(4'h0, 16'h0000, "R9 status after init");

    // R4 / R7: edge on masked source 0
    src_i = 16'h0001;
    idle(4);
    rd(4'h0, 16'h0001, "R4 R7 status set while masked");
    chk_irq(1'b1, "R6 masked source keeps irq high"); idle(1);

    // R6 unmask bit 0
    wr(4'h2, 16'hFFFE);
    idle(1);
    chk_irq(1'b0, "R6 unmasked pending drives irq low"); idle(1);

    // R5 / R8 clear, level held does not re-set (R4)
    wr(4'h4, 16'h0001);
    idle(2);
    rd(4'h0, 16'h0000, "R5 status cleared");
    chk_irq(1'b1, "R8 irq high after clear"); idle(1);
    wr(4'h4, 16'h0000);
    idle(3);
    rd(4'h0, 16'h0000, "R4 held level does not re-set");

    // R5 clear wins over an arriving edge
    wr(4'h4, 16'h0002);
    src_i = 16'h0003;
    idle(5);
    rd(4'h0, 16'h0000, "R5 held clear blocks edge");
    wr(4'h4, 16'h0000);
    idle(3);
    rd(4'h0, 16'h0000, "R5 R4 no edge after clear release");
    src_i = 16'h0001;
    idle(3);
    src_i = 16'h0003;
    idle(4);
    rd(4'h0, 16'h0002, "R4 fresh edge sets bit 1");
    chk_irq(1'b1, "R6 bit 1 masked"); idle(1);

    // R5 zero bits of clear have no effect
    wr(4'h4, 16'hFFFD);
    idle(3);
    rd(4'h0, 16'h0002, "R5 zero clear bit leaves status");
    wr(4'h4, 16'h0000);

    // R6 / R8 top source and release timing
    src_i = 16'h8003;
    idle(4);
    rd(4'h0, 16'h8002, "R4 bit 15 set");
    wr(4'h2, 16'h7FFF);
    idle(1);
    chk_irq(1'b0, "R6 bit 15 unmasked drives irq low"); idle(1);
    wr(4'h4, 16'h8000);
    chk_irq(1'b0, "R8 irq still low one edge after clear write");
    idle(1);
    chk_irq(1'b1, "R8 irq high second edge after clear write");
    idle(2);
    rd(4'h0, 16'h0002, "R5 only cleared bit dropped");
    wr(4'h4, 16'h0000);

    idle(3);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule